// File: doc/BRIEF.md
# Pipelined Cascadable Parity Checker

This block checks a ten-bit data word against a parity bit that arrives one clock after the word. The word's parity is computed when the word is captured and carried forward one stage, so that it lines up with the late parity bit. One clock after the parity bit is taken, a registered error flag reports whether the two agree. The flag leaves the block as a pull-low enable. The flag's pin is open drain, so it is pulled low only on an error and reads high through an external pull-up otherwise.

A shared parity port has two roles. When its direction control is high, the port is an input. In single use it carries the polarity choice, with low meaning even and high meaning odd. In the second checker of a chained pair it carries the partial sum from the first checker. When the direction control is low, the port drives out the XOR of the held data parity and the captured parity bit. A second checker folds that value into its own test. An error-mask input forces the flag to its no-error state. An output-off input releases the error pin without disturbing any internal state.

Top module: `parity_chain_top`

## Requirements
- R1: While `rst` is high at a clock edge, every pipeline register clears. After that edge `err_pull` and `par_io_out` are 0.
- R2: Parity covers all bits of `data_in[9:0]` and nothing else. The parity bit, the mask and the output-off input do not enter the data parity.
- R3: A word captured at edge k is paired with the `par_bit` captured at edge k+1. The error register loads at edge k+2, and the result shows on `err_pull` after that edge. The result shows neither earlier nor later.
- R4: With `dir_in`=1 and `par_io_in`=0 (even), the flag is set when the count of ones in the word plus `par_bit` is odd.
- R5: With `dir_in`=1 and `par_io_in`=1 (odd), the flag is set when the count of ones in the word plus `par_bit` is even.
- R6: After edge k+1, `par_io_out` equals XOR(parity of the word from edge k, `par_bit` from edge k+1). `par_io_oe`=1 whenever `dir_in`=0.
- R7: With `dir_in`=1, `par_io_in` is folded by XOR into the check sampled at edge k+2. This holds for a partial sum from another checker just as for a polarity choice. With `dir_in`=0, the fold term is 0, so the check is even.
- R8: If `err_mask`=1 at the edge where the error register loads, the register loads 0, which means no error.
- R9: While `out_off`=1, `err_pull`=0. Pipeline state is unaffected, so a pending error shows as soon as `out_off` returns to 0.
- R10: While `dir_in`=1, `par_io_oe`=0, so the parity port is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 10 | Data word covered by parity |
| par_bit | input | 1 | Parity bit, one cycle after its word |
| dir_in | input | 1 | 1: parity port is an input; 0: port drives the partial sum |
| par_io_in | input | 1 | Value seen on the parity port (polarity or partial sum) |
| par_io_out | output | 1 | Partial sum driven onto the parity port |
| par_io_oe | output | 1 | Drive enable for the parity port |
| err_mask | input | 1 | Forces the flag to no-error when high |
| out_off | input | 1 | Releases the error pin when high |
| err_pull | output | 1 | 1: pull the error pin low (error present) |

## Verification
A stale or misaligned held data parity shows up in two places. It corrupts `par_io_out` one edge after the word is captured. It corrupts `err_pull` one edge after that. A one-cycle skew between the data and parity stages therefore shows within two clocks of any word whose parity differs from its neighbour's. A fault in the error register or its mask shows on `err_pull` at the very next edge. The sole exception is a window where `out_off` hides it, and the hidden error must then appear when `out_off` drops.

// File: rtl/parity_chain_pkg.sv
package parity_chain_pkg;
    localparam int DATA_W = 10;

    typedef struct packed {
        logic word_par;   // parity of the held word
        logic late_par;   // parity bit captured one edge later
    } pair_t;

    function automatic logic word_parity(input logic [DATA_W-1:0] w);
        return ^w;
    endfunction
endpackage

// File: rtl/parity_align.sv
module parity_align
    import parity_chain_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] data_in,
    input  logic         par_bit,
    output pair_t        pair_q
);
    logic fresh_par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh_par_q <= 1'b0;
            pair_q      <= '0;
        end else begin
            fresh_par_q     <= ^data_in;
            pair_q.word_par <= fresh_par_q;
            pair_q.late_par <= par_bit;
        end
    end
endmodule

// File: rtl/parity_judge.sv
module parity_judge
    import parity_chain_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pair_t pair_q,
    input  logic  fold_bit,
    input  logic  err_mask,
    output logic  err_q
);
    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else
            err_q <= ~err_mask & (pair_q.word_par ^ pair_q.late_par ^ fold_bit);
    end

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err_mask |=> !err_q);

    // R3
    rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> $past(!err_mask));
endmodule

// File: rtl/parity_chain_top.sv
module parity_chain_top
    import parity_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_bit,
    input  logic              dir_in,
    input  logic              par_io_in,
    output logic              par_io_out,
    output logic              par_io_oe,
    input  logic              err_mask,
    input  logic              out_off,
    output logic              err_pull
);
    pair_t pair_q;
    logic  fold_bit;
    logic  err_q;

    parity_align #(.W(DATA_W)) u_align (
        .clk     (clk),
        .rst     (rst),
        .data_in (data_in),
        .par_bit (par_bit),
        .pair_q  (pair_q)
    );

    assign fold_bit = dir_in & par_io_in;

    parity_judge u_judge (
        .clk      (clk),
        .rst      (rst),
        .pair_q   (pair_q),
        .fold_bit (fold_bit),
        .err_mask (err_mask),
        .err_q    (err_q)
    );

    assign par_io_out = pair_q.word_par ^ pair_q.late_par;
    assign par_io_oe  = ~dir_in;
    assign err_pull   = err_q & ~out_off;

    // cycles since reset, saturating, for the checks below
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)
            warm_q <= 2'd0;
        else if (warm_q != 2'd3)
            warm_q <= warm_q + 2'd1;
    end

    // R6
    partial_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 2'd2) |-> (par_io_out == (word_parity($past(data_in, 2)) ^ $past(par_bit))));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (rst)
        out_off |-> !err_pull);

    // R10
    port_dir_chk: assert property (@(posedge clk) disable iff (rst)
        dir_in |-> !par_io_oe);
endmodule

// File: tb/parity_chain_top_test.sv
module parity_chain_top_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] data_in;
    logic       par_bit, dir_in, par_io_in, err_mask, out_off;
    logic       par_io_out, par_io_oe, err_pull;

    int checks = 0;
    int failures = 0;

    // bench model state, built from the requirements
    logic m_fresh, m_word, m_late, m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    parity_chain_top uut (
        .clk(clk), .rst(rst), .data_in(data_in), .par_bit(par_bit),
        .dir_in(dir_in), .par_io_in(par_io_in), .par_io_out(par_io_out),
        .par_io_oe(par_io_oe), .err_mask(err_mask), .out_off(out_off),
        .err_pull(err_pull)
    );

    function automatic logic count_odd(input logic [9:0] w);
        int n = 0;
        for (int i = 0; i < 10; i++) n += w[i];
        return n[0];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // drive at negedge, model the edge, then check after it
    task automatic step(input logic [9:0] d, input logic p, input logic dr,
                        input logic pio, input logic mk, input logic off,
                        input string req);
        logic n_err;
        @(negedge clk);
        data_in = d; par_bit = p; dir_in = dr; par_io_in = pio;
        err_mask = mk; out_off = off;
        @(posedge clk);
        n_err   = ~mk & (m_word ^ m_late ^ (dr & pio));
        m_err   = n_err;
        m_word  = m_fresh;
        m_late  = p;
        m_fresh = count_odd(d);
        #1;
        check({req, " err_pull"}, err_pull, m_err & ~off);
        check({req, " par_io_out"}, par_io_out, m_word ^ m_late);
        check({req, " par_io_oe"}, par_io_oe, ~dr);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; data_in = '0; par_bit = 0; dir_in = 1; par_io_in = 0;
        err_mask = 0; out_off = 0;
        m_fresh = 0; m_word = 0; m_late = 0; m_err = 0;
        repeat (2) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 err_pull", err_pull, 1'b0);
        check("R1 par_io_out", par_io_out, 1'b0);
        @(negedge clk); rst = 1'b0;

        // R3 / R4: odd word, parity 0, even polarity -> error two edges later
        step(10'b0000000001, 0, 1, 0, 0, 0, "R3");
        check("R3 not early", err_pull, 1'b0);
        step(10'b0000000000, 0, 1, 0, 0, 0, "R3");
        check("R3 not yet", err_pull, 1'b0);
        step(10'b0000000000, 0, 1, 0, 0, 0, "R4");
        check("R4 flag set", err_pull, 1'b1);
        step(10'b0000000000, 0, 1, 0, 0, 0, "R3");
        check("R3 one cycle only", err_pull, 1'b0);

        // R5: even word, parity 0, odd polarity -> error
        step(10'b1100000011, 0, 1, 1, 0, 0, "R5");
        step(10'b0, 0, 1, 1, 0, 0, "R5");
        step(10'b0, 1, 1, 1, 0, 0, "R5");
        check("R5 odd polarity error", err_pull, 1'b1);

        // R2: all ten bits counted (bit 9 alone is odd)
        step(10'b1000000000, 1, 1, 0, 0, 0, "R2");
        step(10'b0, 1, 1, 0, 0, 0, "R2");
        step(10'b0, 0, 1, 0, 0, 0, "R2");
        check("R2 bit9 counted, no error", err_pull, 1'b0);

        // R6 partial sum driven with dir low
        step(10'b0000000111, 0, 0, 1, 0, 0, "R6");
        step(10'b0, 0, 0, 1, 0, 0, "R6");
        check("R6 partial sum", par_io_out, 1'b1);
        check("R6 driving", par_io_oe, 1'b1);
        // R7: dir low ignores par_io_in (fold 0) -> even check of odd sum = error
        step(10'b0, 0, 0, 1, 0, 0, "R7");
        check("R7 dir low fold zero", err_pull, 1'b1);

        // R7: partial sum 1 from first checker cancels own odd sum
        step(10'b0000000001, 0, 1, 1, 0, 0, "R7");
        step(10'b0, 0, 1, 1, 0, 0, "R7");
        step(10'b0, 0, 1, 1, 0, 0, "R7");
        check("R7 folded partial sum", err_pull, 1'b0);

        // R8: mask at loading edge
        step(10'b0000000001, 0, 1, 0, 0, 0, "R8");
        step(10'b0, 0, 1, 0, 0, 0, "R8");
        step(10'b0, 0, 1, 0, 1, 0, "R8");
        check("R8 masked", err_pull, 1'b0);

        // R9: hidden then shown
        step(10'b0000000001, 0, 1, 0, 0, 1, "R9");
        step(10'b0, 0, 1, 0, 0, 1, "R9");
        step(10'b0, 0, 1, 0, 0, 1, "R9");
        check("R9 released", err_pull, 1'b0);
        @(negedge clk); out_off = 1'b0; #1;
        check("R9 pending error shows", err_pull, 1'b1);

        // R10 released port
        step(10'b0, 0, 1, 0, 0, 0, "R10");
        check("R10 port released", par_io_oe, 1'b0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[9:0], r[10], r[11] | r[12], r[13], (r[15:14] == 2'b00),
                 (r[18:16] == 3'b000), "R4/R5/R6/R7 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule